// File: doc/BRIEF.md
# 8-bit ALU with status flags

A purely combinational arithmetic and logic unit for a small 8-bit accumulator processor. Each cycle the datapath presents a 4-bit operation code, the accumulator-side operand `a_i`, the memory-side operand `m_i` and the current carry. The unit returns the 8-bit result, the next values of the negative, overflow, zero and carry flags, and a mask that says which of those four flags the operation updates. The caller merges the flags under the mask into its own status register. The caller also writes back the result when `result_valid_o` is high.

Supported functions are add and subtract through the carry, bitwise AND, OR and exclusive OR, shifts and rotates through carry, compare, bit test, increment and decrement. Arithmetic is always binary. No decimal adjust takes place, and no decimal-mode input exists. Compare works against whichever register the caller places on `a_i`, so one code serves accumulator, X and Y compares. Shifts, rotates, increment and decrement act on `a_i`, and `m_i` has no effect for them.

Top module: `alu8_flags`

## Requirements
- R1: Code 0 (add) returns a_i + m_i + carry_i modulo 256. C is the carry out of bit 7, V is set when both operands share a sign that the result lacks, and the mask is 4'b1111.
- R2: Code 1 (subtract) returns a_i − m_i − (1 − carry_i) modulo 256. C is 0 exactly when a borrow occurs, V flags a signed overflow, and the mask is 4'b1111.
- R3: Codes 2, 3 and 4 return a_i AND, OR and XOR m_i. Their mask is 4'b1010, so only N and Z are updated.
- R4: Code 5 shifts a_i left, filling bit 0 with 0, and C takes the old bit 7. Code 6 shifts a_i right, filling bit 7 with 0, and C takes the old bit 0. The mask is 4'b1011, and carry_i has no effect.
- R5: Code 7 rotates a_i left with bit 0 taken from carry_i. Code 8 rotates a_i right with bit 7 taken from carry_i. The bit shifted out becomes C, and the mask is 4'b1011.
- R6: Code 9 (compare) forms a_i − m_i without a write. result_valid_o is 0 and result_o is 0. C = (a_i ≥ m_i) unsigned, Z = (a_i == m_i), and N = bit 7 of the difference. carry_i is ignored, and the mask is 4'b1011.
- R7: Code 10 (bit test) sets Z when (a_i AND m_i) is zero, N = m_i[7] and V = m_i[6]. result_valid_o is 0, result_o is 0, and the mask is 4'b1110.
- R8: Code 11 returns a_i + 1 and code 12 returns a_i − 1, both wrapping modulo 256. The mask is 4'b1010, and carry_i has no effect.
- R9: For every operation whose mask covers N or Z, N equals bit 7 of the written result and Z is set when that result is zero. Compare and bit test follow their own rules in R6 and R7.
- R10: flags_o and flag_mask_o are ordered {N, V, Z, C} on bits 3..0. Any flag outside the mask reads 0. Codes 13–15 give result 0, result_valid_o 0, mask 0 and flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R1–R10) |
| a_i | input | 8 | Register-side operand |
| m_i | input | 8 | Memory-side operand |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Operation result |
| result_valid_o | output | 1 | High when result_o is to be written back |
| flags_o | output | 4 | Next {N, V, Z, C} |
| flag_mask_o | output | 4 | Flags updated by this operation, {N, V, Z, C} |

## Verification
Several flag functions can fire on the same vector. The sharpest case is an add of 0x80 and 0x80, where the carry out, the signed overflow and the zero result are all set at once. A compare of equal operands also sets Z and C together. The directed vectors provoke these cases on purpose, with and without an incoming carry. Each is judged by comparing the full four-bit flag word and the mask against values worked out by hand, so a design that drops one of the coincident flags, or lets a flag outside the mask leak, is caught.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_AND = 4'd2,  OP_OR  = 4'd3,
    OP_XOR = 4'd4,  OP_ASL = 4'd5,  OP_LSR = 4'd6,  OP_ROL = 4'd7,
    OP_ROR = 4'd8,  OP_CMP = 4'd9,  OP_BIT = 4'd10, OP_INC = 4'd11,
    OP_DEC = 4'd12
  } alu_op_e;

  // flag word bit positions, {N,V,Z,C}
  localparam int unsigned FN = 3;
  localparam int unsigned FV = 2;
  localparam int unsigned FZ = 1;
  localparam int unsigned FC = 0;
  localparam int unsigned NFLAGS = 4;

  localparam logic [NFLAGS-1:0] MASK_ALL  = 4'b1111;
  localparam logic [NFLAGS-1:0] MASK_NZ   = 4'b1010;
  localparam logic [NFLAGS-1:0] MASK_NZC  = 4'b1011;
  localparam logic [NFLAGS-1:0] MASK_NVZ  = 4'b1110;
  localparam logic [NFLAGS-1:0] MASK_NONE = 4'b0000;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          carry_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          ovf_o
);
  localparam int unsigned MSB = DW - 1;

  logic [DW-1:0] b_op;
  logic          cin;
  logic [DW:0]   wide;

  // one adder serves add, subtract, compare, increment, decrement
  always_comb begin
    unique case (op_i)
      OP_SUB:  begin b_op = ~m_i;     cin = carry_i; end
      OP_CMP:  begin b_op = ~m_i;     cin = 1'b1;    end
      OP_INC:  begin b_op = '0;       cin = 1'b1;    end
      OP_DEC:  begin b_op = '1;       cin = 1'b0;    end
      default: begin b_op = m_i;      cin = carry_i; end
    endcase
  end

  assign wide   = {1'b0, a_i} + {1'b0, b_op} + {{DW{1'b0}}, cin};
  assign sum_o  = wide[DW-1:0];
  assign cout_o = wide[DW];
  assign ovf_o  = (a_i[MSB] == b_op[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_OR:   res_o = a_i | m_i;
      OP_XOR:  res_o = a_i ^ m_i;
      default: res_o = a_i & m_i; // AND and bit test
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic          carry_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);
  localparam int unsigned MSB = DW - 1;

  logic left;
  logic fill;

  assign left = (op_i == OP_ASL) || (op_i == OP_ROL);
  assign fill = ((op_i == OP_ROL) || (op_i == OP_ROR)) ? carry_i : 1'b0;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign res_o[i] = left ? fill : a_i[i+1];
    end else if (i == MSB) begin : g_hi
      assign res_o[i] = left ? a_i[i-1] : fill;
    end else begin : g_mid
      assign res_o[i] = left ? a_i[i-1] : a_i[i+1];
    end
  end

  assign cout_o = left ? a_i[MSB] : a_i[0];
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [3:0]        op_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     m_i,
  input  logic              carry_i,
  output logic [DW-1:0]     result_o,
  output logic              result_valid_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic [NFLAGS-1:0] flag_mask_o
);
  localparam int unsigned MSB = DW - 1;

  alu_op_e       op;
  logic [DW-1:0] add_sum, log_res, sh_res;
  logic          add_c, add_v, sh_c;
  logic [DW-1:0] raw;
  logic [NFLAGS-1:0] nxt, msk;
  logic          vld;

  assign op = alu_op_e'(op_i);

  alu8_addsub #(.DW(DW)) u_addsub (
    .op_i(op), .a_i(a_i), .m_i(m_i), .carry_i(carry_i),
    .sum_o(add_sum), .cout_o(add_c), .ovf_o(add_v)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op_i(op), .a_i(a_i), .m_i(m_i), .res_o(log_res)
  );

  alu8_shift #(.DW(DW)) u_shift (
    .op_i(op), .a_i(a_i), .carry_i(carry_i),
    .res_o(sh_res), .cout_o(sh_c)
  );

  always_comb begin
    raw = '0;
    nxt = '0;
    msk = MASK_NONE;
    vld = 1'b0;
    unique case (op_i)
      OP_ADD, OP_SUB: begin
        raw = add_sum; vld = 1'b1; msk = MASK_ALL;
        nxt[FC] = add_c; nxt[FV] = add_v;
      end
      OP_AND, OP_OR, OP_XOR: begin
        raw = log_res; vld = 1'b1; msk = MASK_NZ;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        raw = sh_res; vld = 1'b1; msk = MASK_NZC;
        nxt[FC] = sh_c;
      end
      OP_INC, OP_DEC: begin
        raw = add_sum; vld = 1'b1; msk = MASK_NZ;
      end
      OP_CMP: begin
        raw = add_sum; msk = MASK_NZC;
        nxt[FC] = add_c; // no borrow => a >= m
      end
      OP_BIT: begin
        raw = log_res; msk = MASK_NVZ;
      end
      default: ;
    endcase

    if (op_i == OP_BIT) begin
      nxt[FN] = m_i[MSB];
      nxt[FV] = m_i[MSB-1];
    end else begin
      nxt[FN] = raw[MSB];
    end
    nxt[FZ] = (raw == '0);
  end

  assign result_o       = vld ? raw : '0;
  assign result_valid_o = vld;
  assign flags_o        = nxt & msk;
  assign flag_mask_o    = msk;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic [3:0]        op_i,
  input logic [DW-1:0]     a_i,
  input logic [DW-1:0]     m_i,
  input logic              carry_i,
  input logic [DW-1:0]     result_o,
  input logic              result_valid_o,
  input logic [NFLAGS-1:0] flags_o,
  input logic [NFLAGS-1:0] flag_mask_o
);
  logic known;
  assign known = !$isunknown({op_i, a_i, m_i, carry_i});

  always_comb begin
    if (known) begin
      assert_mask_gates_flags_R10: assert ((flags_o & ~flag_mask_o) == '0)
        else $error("flag outside mask");
      if (op_i == OP_CMP || op_i == OP_BIT) begin
        assert_no_write_R6: assert (!result_valid_o && result_o == '0)
          else $error("compare/bit test wrote a result");
      end
      if (op_i == OP_BIT) begin
        assert_bit_copy_R7: assert (flags_o[FN] == m_i[DW-1] && flags_o[FV] == m_i[DW-2])
          else $error("bit test copy wrong");
      end
      if (op_i == OP_INC || op_i == OP_DEC) begin
        assert_incdec_mask_R8: assert (flag_mask_o == MASK_NZ)
          else $error("inc/dec mask wrong");
      end
      if (result_valid_o && flag_mask_o[FZ]) begin
        assert_zero_tracks_R9: assert (flags_o[FZ] == (result_o == '0))
          else $error("Z does not follow result");
      end
      if (result_valid_o && flag_mask_o[FN]) begin
        assert_neg_tracks_R9: assert (flags_o[FN] == result_o[DW-1])
          else $error("N does not follow result");
      end
    end
  end
endmodule

bind alu8_flags alu8_flags_chk #(.DW(DW)) u_chk (
  .op_i(op_i), .a_i(a_i), .m_i(m_i), .carry_i(carry_i),
  .result_o(result_o), .result_valid_o(result_valid_o),
  .flags_o(flags_o), .flag_mask_o(flag_mask_o)
);

// File: tb/alu8_flags_bench.sv
`timescale 1ns/1ps
module alu8_flags_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic [3:0] op_i;
  logic [7:0] a_i, m_i;
  logic       carry_i;
  logic [7:0] result_o;
  logic       result_valid_o;
  logic [3:0] flags_o, flag_mask_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  alu8_flags u_alu8_flags (
    .op_i(op_i), .a_i(a_i), .m_i(m_i), .carry_i(carry_i),
    .result_o(result_o), .result_valid_o(result_valid_o),
    .flags_o(flags_o), .flag_mask_o(flag_mask_o)
  );

  // flags and masks are {N,V,Z,C}
  task automatic chk(input string tag, input logic [3:0] op, input logic [7:0] a,
                     input logic [7:0] m, input logic c, input logic [7:0] e_res,
                     input logic e_vld, input logic [3:0] e_fl, input logic [3:0] e_mk);
    @(negedge clk);
    op_i = op; a_i = a; m_i = m; carry_i = c;
    #2;
    n_vec++;
    if (result_o !== e_res || result_valid_o !== e_vld ||
        flags_o !== e_fl || flag_mask_o !== e_mk) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h m=%h c=%b: got res=%h vld=%b fl=%b mk=%b, exp res=%h vld=%b fl=%b mk=%b",
               tag, op, a, m, c, result_o, result_valid_o, flags_o, flag_mask_o,
               e_res, e_vld, e_fl, e_mk);
    end
  endtask

  task automatic test_reset();
    chk("R9 reset", 4'd0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 4'b0010, 4'b1111);
  endtask

  task automatic test_add();
    chk("R1 signed ovf", 4'd0, 8'h50, 8'h50, 1'b0, 8'hA0, 1'b1, 4'b1100, 4'b1111);
    chk("R1 carry zero", 4'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 4'b0011, 4'b1111);
    chk("R1 cvz same",   4'd0, 8'h80, 8'h80, 1'b0, 8'h00, 1'b1, 4'b0111, 4'b1111);
    chk("R1 carry in",   4'd0, 8'h80, 8'h80, 1'b1, 8'h01, 1'b1, 4'b0101, 4'b1111);
  endtask

  task automatic test_sub();
    chk("R2 no borrow",  4'd1, 8'h05, 8'h03, 1'b1, 8'h02, 1'b1, 4'b0001, 4'b1111);
    chk("R2 borrow",     4'd1, 8'h03, 8'h05, 1'b1, 8'hFE, 1'b1, 4'b1000, 4'b1111);
    chk("R2 borrow in",  4'd1, 8'h05, 8'h03, 1'b0, 8'h01, 1'b1, 4'b0001, 4'b1111);
    chk("R2 signed ovf", 4'd1, 8'h80, 8'h01, 1'b1, 8'h7F, 1'b1, 4'b0101, 4'b1111);
  endtask

  task automatic test_logic();
    chk("R3 and", 4'd2, 8'hF0, 8'h3C, 1'b1, 8'h30, 1'b1, 4'b0000, 4'b1010);
    chk("R3 or",  4'd3, 8'h80, 8'h01, 1'b0, 8'h81, 1'b1, 4'b1000, 4'b1010);
    chk("R3 xor", 4'd4, 8'h5A, 8'h5A, 1'b0, 8'h00, 1'b1, 4'b0010, 4'b1010);
  endtask

  task automatic test_shift();
    chk("R4 asl", 4'd5, 8'h81, 8'hFF, 1'b1, 8'h02, 1'b1, 4'b0001, 4'b1011);
    chk("R4 lsr", 4'd6, 8'h01, 8'hFF, 1'b1, 8'h00, 1'b1, 4'b0011, 4'b1011);
    chk("R4 lsr msb", 4'd6, 8'hFE, 8'h00, 1'b0, 8'h7F, 1'b1, 4'b0000, 4'b1011);
  endtask

  task automatic test_rotate();
    chk("R5 rol", 4'd7, 8'h80, 8'h00, 1'b1, 8'h01, 1'b1, 4'b0001, 4'b1011);
    chk("R5 ror", 4'd8, 8'h01, 8'h00, 1'b1, 8'h80, 1'b1, 4'b1001, 4'b1011);
    chk("R5 ror c0", 4'd8, 8'h02, 8'h00, 1'b0, 8'h01, 1'b1, 4'b0000, 4'b1011);
  endtask

  task automatic test_compare();
    chk("R6 equal", 4'd9, 8'h40, 8'h40, 1'b0, 8'h00, 1'b0, 4'b0011, 4'b1011);
    chk("R6 less",  4'd9, 8'h10, 8'h20, 1'b1, 8'h00, 1'b0, 4'b1000, 4'b1011);
    chk("R6 greater", 4'd9, 8'h20, 8'h10, 1'b0, 8'h00, 1'b0, 4'b0001, 4'b1011);
  endtask

  task automatic test_bit();
    chk("R7 zero nv", 4'd10, 8'h0F, 8'hC0, 1'b1, 8'h00, 1'b0, 4'b1110, 4'b1110);
    chk("R7 nonzero", 4'd10, 8'h01, 8'h01, 1'b0, 8'h00, 1'b0, 4'b0000, 4'b1110);
    chk("R7 v only",  4'd10, 8'hFF, 8'h40, 1'b0, 8'h00, 1'b0, 4'b0100, 4'b1110);
  endtask

  task automatic test_incdec();
    chk("R8 inc wrap", 4'd11, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 4'b0010, 4'b1010);
    chk("R8 dec wrap", 4'd12, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 4'b1000, 4'b1010);
    chk("R8 inc sign", 4'd11, 8'h7F, 8'h55, 1'b0, 8'h80, 1'b1, 4'b1000, 4'b1010);
  endtask

  task automatic test_reserved();
    for (int k = 13; k < 16; k++)
      chk("R10 reserved", 4'(k), 8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 4'b0000, 4'b0000);
  endtask

  initial begin
    op_i = 4'd0; a_i = 8'h00; m_i = 8'h00; carry_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    test_reset();
    test_add();
    test_sub();
    test_logic();
    test_shift();
    test_rotate();
    test_compare();
    test_bit();
    test_incdec();
    test_reserved();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule